// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Unit

This block sits behind the command decoder of a serial NOR flash controller. It holds the status byte and decides, for every decoded instruction strobe, whether the instruction may run. Write enable and write disable only change the write-enable latch. A status write, page program, sector erase or bulk erase needs that latch to be set. A program or sector erase is also refused when its target sector lies inside the protected region. When a cycle is accepted, the block pulses the program/erase engine and reports busy until the engine signals done.

The protected region is set by a 3-bit level field and a direction bit. Bulk erase is allowed only when the level is zero. A status-write lock bit, combined with a low level on the write-protect pin, freezes the protection fields. The non-volatile fields are plain registers that return to zero on reset. The array has 2 MiB in 32 sectors of 64 KiB each.

Top module: `flash_guard`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: Status byte layout, MSB first: bit 7 lock (SRWD), bit 6 always 0, bit 5 direction (TB), bits 4..2 level (BP), bit 1 write-enable latch (WEL), bit 0 busy (WIP).
- R3: An idle write enable is accepted and sets WEL. An idle write disable is accepted and clears WEL.
- R4: With WEL at 0, status write, page program, sector erase and bulk erase are refused and give no engine start.
- R5: An accepted status write, program or erase raises `eng_start` for exactly that cycle. WIP reads 1 from the next cycle until the clock edge where `eng_done` is high, and WEL clears at that same edge. `eng_done` while idle has no effect. A refused instruction leaves WEL unchanged.
- R6: While WIP is 1, every strobe (write enable and write disable included) is refused and the status byte does not change.
- R7: An accepted status write loads data bits 7, 5, 4, 3, 2 into SRWD, TB and BP at the next edge. Data bits 6, 1 and 0 are ignored.
- R8: With SRWD at 1 and `wp_n` low, a status write is refused. With `wp_n` high it is accepted.
- R9: With TB=0 and BP=n (n from 1 to 5), the top 2^(n-1) sectors (sector = addr[20:16]) are protected. Program and sector erase there are refused, and they are accepted elsewhere.
- R10: With TB=1 and BP=n (n from 1 to 5), the protected sectors are 0 through 2^(n-1)-1.
- R11: With BP at 6 or 7, every sector is protected, whatever TB is.
- R12: Bulk erase is refused when BP is nonzero and accepted (with WEL set) when BP is 0.
- R13: For a cycle with exactly one strobe, exactly one of `cmd_accept` and `cmd_reject` is high. With no strobe both are low. With two or more strobes the cycle is refused and nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Write enable strobe |
| cmd_wrdi | input | 1 | Write disable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte for a status write |
| cmd_pp | input | 1 | Page program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_be | input | 1 | Bulk erase strobe |
| addr | input | 21 | Target byte address |
| wp_n | input | 1 | Write-protect pin level (low = asserted) |
| eng_done | input | 1 | Engine completion |
| status | output | 8 | Status byte |
| cmd_accept | output | 1 | Strobe accepted this cycle |
| cmd_reject | output | 1 | Strobe refused this cycle |
| eng_start | output | 1 | One-cycle engine start |

## Verification
The bench probes each region edge, one sector inside and one sector outside, for both directions and for several levels. A decoder that is off by one there would program a protected sector or refuse a free one. It checks that busy blocks write enable and write disable too, since a design that gates only the engine-bound instructions would let WEL change in mid-cycle. It loads 0xFF through a status write to show that bits 6, 1 and 0 are not written from the data. It also tries the hardware lock with the pin at each level, which catches a lock that ignores the pin or ignores the lock bit.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int BP_W = 3;

  typedef struct packed {
    logic            srwd;
    logic            tb;
    logic [BP_W-1:0] bp;
  } nv_bits_t;

  // Status byte bit positions
  localparam int ST_WIP  = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_BP0  = 2;
  localparam int ST_TB   = 5;
  localparam int ST_SRWD = 7;
endpackage

// File: rtl/fsp_region.sv
module fsp_region
  import fsp_pkg::*;
#(
  parameter int SECT_W = 5
) (
  input  logic [SECT_W-1:0] sector,
  input  logic [BP_W-1:0]   bp,
  input  logic              tb,
  output logic              locked,
  output logic              any_prot
);
  localparam int SZ_W = SECT_W + 1;

  logic [31:0]     span_log;
  logic            whole;
  logic [SZ_W-1:0] span;
  logic            in_top;
  logic            in_bot;

  always_comb begin
    any_prot = (bp != '0);
    span_log = 32'(bp) - 32'd1;
    whole    = any_prot && (span_log >= 32'(SECT_W));
    span     = whole ? '0 : (SZ_W'(1) << span_log[4:0]);
    // distance from the top end equals the inverted sector index
    in_top   = ({1'b0, ~sector} < span);
    in_bot   = ({1'b0, sector} < span);
    locked   = any_prot && (whole || (tb ? in_bot : in_top));
  end
endmodule

// File: rtl/fsp_status_reg.sv
module fsp_status_reg
  import fsp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wel_set,
  input  logic     wel_clr,
  input  logic     nv_load,
  input  nv_bits_t nv_in,
  output nv_bits_t nv_q,
  output logic     wel_q
);
  nv_bits_t nv_d;
  logic     wel_d;
  logic     nv_en;
  logic     wel_en;

  always_comb begin
    nv_en  = nv_load;
    nv_d   = nv_in;
    wel_en = wel_set | wel_clr;
    wel_d  = wel_set & ~wel_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q <= '0;
    end else if (nv_en) begin
      nv_q <= nv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (wel_en) begin
      wel_q <= wel_d;
    end
  end
endmodule

// File: rtl/fsp_busy.sv
module fsp_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy_q,
  output logic finish
);
  logic busy_d;
  logic busy_en;

  always_comb begin
    finish  = busy_q & done;
    busy_en = start | finish;
    busy_d  = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fsp_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int SECT_BYTES_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  input  logic              eng_done,
  output logic [7:0]        status,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              eng_start
);
  localparam int SECT_W = ADDR_W - SECT_BYTES_W;
  localparam int N_CMD  = 6;

  nv_bits_t          nv_q;
  nv_bits_t          nv_new;
  logic              wel_q;
  logic              wip_q;
  logic              cyc_end;
  logic              locked;
  logic              any_prot;
  logic              hw_lock;
  logic [N_CMD-1:0]  strobes;
  logic [N_CMD-1:0]  allowed;
  logic              single;
  logic              grant;
  logic              addr_unused;
  logic              data_unused;

  assign addr_unused = ^addr[SECT_BYTES_W-1:0];
  assign data_unused = ^{wrsr_data[6], wrsr_data[1:0]};

  fsp_region #(.SECT_W(SECT_W)) u_region (
    .sector   (addr[ADDR_W-1:SECT_BYTES_W]),
    .bp       (nv_q.bp),
    .tb       (nv_q.tb),
    .locked   (locked),
    .any_prot (any_prot)
  );

  // strobe order: wren, wrdi, wrsr, pp, se, be
  always_comb begin
    strobes    = {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be};
    hw_lock    = nv_q.srwd & ~wp_n;
    allowed[5] = ~wip_q;
    allowed[4] = ~wip_q;
    allowed[3] = ~wip_q & wel_q & ~hw_lock;
    allowed[2] = ~wip_q & wel_q & ~locked;
    allowed[1] = ~wip_q & wel_q & ~locked;
    allowed[0] = ~wip_q & wel_q & ~any_prot;
    single     = $onehot(strobes);
    grant      = single & |(strobes & allowed);
    cmd_accept = grant;
    cmd_reject = (|strobes) & ~grant;
    eng_start  = grant & (cmd_wrsr | cmd_pp | cmd_se | cmd_be);
    nv_new.srwd = wrsr_data[ST_SRWD];
    nv_new.tb   = wrsr_data[ST_TB];
    nv_new.bp   = wrsr_data[ST_BP0 +: BP_W];
  end

  fsp_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wel_set (grant & cmd_wren),
    .wel_clr ((grant & cmd_wrdi) | cyc_end),
    .nv_load (grant & cmd_wrsr),
    .nv_in   (nv_new),
    .nv_q    (nv_q),
    .wel_q   (wel_q)
  );

  fsp_busy u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eng_start),
    .done   (eng_done),
    .busy_q (wip_q),
    .finish (cyc_end)
  );

  assign status = {nv_q.srwd, 1'b0, nv_q.tb, nv_q.bp, wel_q, wip_q};
endmodule

// File: rtl/fsp_guard_chk.sv
module fsp_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wrsr,
  input logic       cmd_be,
  input logic       wp_n,
  input logic [7:0] status,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic       eng_start
);
  // R2
  zero_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] == 1'b0);

  // R4
  start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> status[1]);

  // R5
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> status[0]);

  // R5
  start_is_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> cmd_accept);

  // R6
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (!cmd_accept && !eng_start));

  // R8
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && status[7] && !wp_n) |-> cmd_reject);

  // R12
  bulk_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_be && (status[4:2] != 3'd0)) |-> cmd_reject);

  // R13
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject));
endmodule

bind flash_guard fsp_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_wrsr   (cmd_wrsr),
  .cmd_be     (cmd_be),
  .wp_n       (wp_n),
  .status     (status),
  .cmd_accept (cmd_accept),
  .cmd_reject (cmd_reject),
  .eng_start  (eng_start)
);

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [5:0] C_WREN = 6'b100000;
  localparam logic [5:0] C_WRDI = 6'b010000;
  localparam logic [5:0] C_WRSR = 6'b001000;
  localparam logic [5:0] C_PP   = 6'b000100;
  localparam logic [5:0] C_SE   = 6'b000010;
  localparam logic [5:0] C_BE   = 6'b000001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
  logic        cmd_pp = 1'b0, cmd_se = 1'b0, cmd_be = 1'b0;
  logic [7:0]  wrsr_data = 8'h00;
  logic [20:0] addr = '0;
  logic        wp_n = 1'b1;
  logic        eng_done = 1'b0;
  logic [7:0]  status;
  logic        cmd_accept, cmd_reject, eng_start;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_pp(cmd_pp),
    .cmd_se(cmd_se), .cmd_be(cmd_be), .addr(addr), .wp_n(wp_n),
    .eng_done(eng_done), .status(status), .cmd_accept(cmd_accept),
    .cmd_reject(cmd_reject), .eng_start(eng_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive one strobe pattern for one cycle, check flags in that cycle
  task automatic op(input string req, input logic [5:0] v, input logic [7:0] d,
                    input logic [20:0] a, input bit exp_acc);
    bit eng;
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be} = v;
    wrsr_data = d;
    addr = a;
    #1;
    eng = exp_acc && ((v & 6'b001111) != 0);
    chk(req, {29'd0, cmd_accept, cmd_reject, eng_start},
        {29'd0, exp_acc, (v != 0) && !exp_acc, eng});
    @(posedge clk);
    #1;
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be} = '0;
  endtask

  task automatic st(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, {24'd0, status}, {24'd0, exp});
  endtask

  task automatic done_pulse;
    @(negedge clk);
    eng_done = 1'b1;
    @(posedge clk);
    #1;
    eng_done = 1'b0;
  endtask

  task automatic set_prot(input logic [7:0] d);
    op("R3 wren", C_WREN, 8'h00, '0, 1'b1);
    op("R7 wrsr", C_WRSR, d, '0, 1'b1);
    done_pulse();
    st("R7 loaded", d & 8'hBC);
  endtask

  // program or erase one address with WEL set, expecting the given verdict
  task automatic try_write(input string req, input logic [5:0] v,
                           input logic [20:0] a, input bit exp_acc, input logic [7:0] base);
    op("R3 wren", C_WREN, 8'h00, '0, 1'b1);
    op(req, v, 8'h00, a, exp_acc);
    if (exp_acc) begin
      done_pulse();
      st(req, base);
    end else begin
      st(req, base | 8'h02);
      op("R3 wrdi", C_WRDI, 8'h00, '0, 1'b1);
    end
  endtask

  task automatic t_reset;
    st("R1 reset", 8'h00);
    op("R13 idle", 6'b000000, 8'h00, '0, 1'b0);
  endtask

  task automatic t_wel;
    op("R3 wren", C_WREN, 8'h00, '0, 1'b1);
    st("R3 wel set", 8'h02);
    op("R3 wrdi", C_WRDI, 8'h00, '0, 1'b1);
    st("R3 wel clr", 8'h00);
  endtask

  task automatic t_no_wel;
    op("R4 pp", C_PP, 8'h00, 21'h000100, 1'b0);
    op("R4 se", C_SE, 8'h00, 21'h000100, 1'b0);
    op("R4 be", C_BE, 8'h00, '0, 1'b0);
    op("R4 wrsr", C_WRSR, 8'h9C, '0, 1'b0);
    st("R4 unchanged", 8'h00);
  endtask

  task automatic t_busy;
    op("R3 wren", C_WREN, 8'h00, '0, 1'b1);
    op("R5 pp", C_PP, 8'h00, 21'h000000, 1'b1);
    st("R5 busy", 8'h03);
    st("R5 busy hold", 8'h03);
    op("R6 wrdi busy", C_WRDI, 8'h00, '0, 1'b0);
    op("R6 se busy", C_SE, 8'h00, '0, 1'b0);
    st("R6 unchanged", 8'h03);
    done_pulse();
    st("R5 done", 8'h00);
    done_pulse();
    st("R5 idle done", 8'h00);
  endtask

  task automatic t_wrsr_bits;
    op("R3 wren", C_WREN, 8'h00, '0, 1'b1);
    op("R7 wrsr ff", C_WRSR, 8'hFF, '0, 1'b1);
    st("R7 busy", 8'hBF);
    done_pulse();
    st("R7 masked", 8'hBC);
  endtask

  task automatic t_hw_lock;
    wp_n = 1'b0;
    op("R3 wren", C_WREN, 8'h00, '0, 1'b1);
    op("R8 locked", C_WRSR, 8'h00, '0, 1'b0);
    st("R8 unchanged", 8'hBE);
    wp_n = 1'b1;
    op("R8 pin high", C_WRSR, 8'h00, '0, 1'b1);
    done_pulse();
    st("R8 cleared", 8'h00);
  endtask

  task automatic t_regions;
    try_write("R12 be free", C_BE, '0, 1'b1, 8'h00);
    set_prot(8'h04);
    try_write("R12 be prot", C_BE, '0, 1'b0, 8'h04);
    try_write("R9 bp1 s31", C_PP, 21'h1F0000, 1'b0, 8'h04);
    try_write("R9 bp1 s30", C_PP, 21'h1EFFFF, 1'b1, 8'h04);
    set_prot(8'h0C);
    try_write("R9 bp3 s28", C_SE, 21'h1C0000, 1'b0, 8'h0C);
    try_write("R9 bp3 s27", C_SE, 21'h1B0000, 1'b1, 8'h0C);
    set_prot(8'h14);
    try_write("R9 bp5 s16", C_PP, 21'h100000, 1'b0, 8'h14);
    try_write("R9 bp5 s15", C_PP, 21'h0FFFFF, 1'b1, 8'h14);
    set_prot(8'h28);
    try_write("R10 bp2 s1", C_PP, 21'h01FFFF, 1'b0, 8'h28);
    try_write("R10 bp2 s2", C_PP, 21'h020000, 1'b1, 8'h28);
    try_write("R10 bp2 s31", C_SE, 21'h1F0000, 1'b1, 8'h28);
    set_prot(8'h18);
    try_write("R11 bp6 s0", C_PP, 21'h000000, 1'b0, 8'h18);
    set_prot(8'h3C);
    try_write("R11 bp7 s31", C_SE, 21'h1F0000, 1'b0, 8'h3C);
    set_prot(8'h00);
  endtask

  task automatic t_multi;
    op("R13 two strobes", C_WREN | C_WRDI, 8'h00, '0, 1'b0);
    st("R13 no effect", 8'h00);
    op("R3 wren", C_WREN, 8'h00, '0, 1'b1);
    op("R13 pp+be", C_PP | C_BE, 8'h00, '0, 1'b0);
    st("R13 no start", 8'h02);
    op("R3 wrdi", C_WRDI, 8'h00, '0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_wel();
    t_no_wel();
    t_busy();
    t_wrsr_bits();
    t_hw_lock();
    t_regions();
    t_multi();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule